// File: doc/BRIEF.md
# Loss-of-Reference Pulse Monitor

This block decides whether a reference pulse stream is still arriving. A local feedback strobe, running at the rate the reference is expected to have (for example a divided oscillator), splits time into observation windows. Each window that closes without a reference pulse counts as one missing pulse. Only consecutive misses are counted: a window that holds a pulse sets the count back to zero. When the count goes above a programmable 4-bit threshold, the loss flag is raised.

Two comparator flags report that the loop control voltage is close to the low rail or close to the high rail. Either flag raises the loss flag on its own, whatever the count. The flag can therefore come up before the miss count passes the threshold. Both inputs are synchronous single-cycle strobes in the system clock domain. The analog sensing, the phase comparison and lock detection all sit outside this block.

The window tracker is a two-state machine. `WIN_EMPTY` means no reference pulse yet in the current window, and `WIN_HIT` means one has been seen. The transition `mark` (EMPTY to HIT) fires on a reference pulse that does not coincide with the feedback strobe. The transition `close` (either state to EMPTY) fires on every feedback strobe. The flag register is a second two-state machine. `LOR_CLEAR` moves to `LOR_LOST` on `trip`, which is a rail flag or the next count above the threshold. `LOR_LOST` moves back to `LOR_CLEAR` on `recover`, when neither condition holds.

Top module: `ref_loss_monitor`

## Requirements
- R1: A synchronous active-high reset clears the miss counter, returns the window tracker to `WIN_EMPTY` and drives `lor` low. After reset the counter starts again from zero.
- R2: A window counts as present if a reference pulse arrives in any cycle of it, including the cycle that carries the closing feedback strobe. A present window sets the miss count to zero.
- R3: A window that closes with no reference pulse in it adds exactly one to the miss count. The count changes only in cycles with a feedback strobe.
- R4: `lor` goes high on the clock edge that registers a miss count strictly greater than `thresh`. With `thresh` = 0, one missing window is enough.
- R5: The miss counter is THR_W+1 bits wide and stops at all-ones (31 by default) instead of wrapping. A long outage therefore keeps `lor` high even for `thresh` = 15.
- R6: While `rail_lo` or `rail_hi` is high in a cycle, `lor` is high after the next clock edge, whatever the miss count.
- R7: `lor` is registered. It falls on the edge that closes the first present window, provided neither rail flag is high in that cycle.
- R8: A pulse seen in one window gives no credit to the next window. A window without its own pulse counts as a miss, even when the window before it held a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Reference pulse strobe, one cycle |
| fb_tick | input | 1 | Feedback strobe that closes each observation window |
| thresh | input | THR_W (4) | Largest miss count that is still tolerated |
| rail_lo | input | 1 | Control voltage is near the low rail |
| rail_hi | input | 1 | Control voltage is near the high rail |
| lor | output | 1 | Loss-of-reference flag, registered |

## Verification
The bench sweeps all sixteen thresholds and, for each one, windows one, two and three cycles long. In each setup it runs a miss streak that ends just past the threshold. This separates "greater than" from "greater than or equal", and it also shows whether a count is wrongly added in cycles between strobes. The reference pulse is placed at every position inside a window, including the closing cycle, which tells a correct window latch apart from one that ignores same-cycle or early pulses. A pulse followed by a window with no pulse shows whether the window latch clears at each boundary. Single-cycle pulses on each rail flag, and a 40-window outage at every threshold, separate the rail override and counter saturation from a counter that wraps.

// File: rtl/lor_mon_pkg.sv
package lor_mon_pkg;
    typedef enum logic {
        WIN_EMPTY = 1'b0,
        WIN_HIT   = 1'b1
    } win_state_e;

    typedef enum logic {
        LOR_CLEAR = 1'b0,
        LOR_LOST  = 1'b1
    } lor_state_e;
endpackage

// File: rtl/lor_window_fsm.sv
module lor_window_fsm
    import lor_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic fb_tick,
    output logic win_present
);
    win_state_e state_q, state_d;

    // next-state logic: mark on a pulse, close on every feedback strobe
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_EMPTY: if (fb_tick)        state_d = WIN_EMPTY;
                       else if (ref_pulse) state_d = WIN_HIT;
            WIN_HIT:   if (fb_tick)        state_d = WIN_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WIN_EMPTY;
        else     state_q <= state_d;
    end

    // output: window holds a pulse if one was latched or one arrives now
    always_comb begin
        win_present = ref_pulse || (state_q == WIN_HIT);
    end

    AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
        fb_tick |=> state_q == WIN_EMPTY);                          // R8
    AST_WIN_MARK: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && !fb_tick) |=> state_q == WIN_HIT);            // R2
    AST_WIN_RESET: assert property (@(posedge clk)
        rst |=> state_q == WIN_EMPTY);                              // R1
endmodule

// File: rtl/lor_miss_counter.sv
module lor_miss_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_tick,
    input  logic             win_present,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        cnt_d = cnt_q;
        if (fb_tick) begin
            if (win_present)          cnt_d = '0;
            else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fb_tick |=> $stable(cnt_q));                               // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (fb_tick && !win_present && cnt_q != CNT_MAX)
        |=> cnt_q == $past(cnt_q) + CNT_W'(1));                     // R3
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (fb_tick && win_present) |=> cnt_q == '0);                  // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !win_present) |=> cnt_q == CNT_MAX);   // R5
    AST_CNT_RESET: assert property (@(posedge clk)
        rst |=> cnt_q == '0);                                       // R1
endmodule

// File: rtl/lor_flag_fsm.sv
module lor_flag_fsm
    import lor_mon_pkg::*;
#(
    parameter int THR_W = 4,
    parameter int CNT_W = THR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [THR_W-1:0] thresh,
    input  logic             rail_lo,
    input  logic             rail_hi,
    output logic             lor
);
    lor_state_e state_q, state_d;
    logic       trip;

    always_comb begin
        trip    = rail_lo || rail_hi || (cnt_d > CNT_W'(thresh));
        state_d = state_q;
        unique case (state_q)
            LOR_CLEAR: if (trip)  state_d = LOR_LOST;
            LOR_LOST:  if (!trip) state_d = LOR_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LOR_CLEAR;
        else     state_q <= state_d;
    end

    always_comb begin
        lor = (state_q == LOR_LOST);
    end

    AST_RAIL_FORCE: assert property (@(posedge clk) disable iff (rst)
        (rail_lo || rail_hi) |=> lor);                              // R6
    AST_LOR_RESET: assert property (@(posedge clk)
        rst |=> !lor);                                              // R1
endmodule

// File: rtl/ref_loss_monitor.sv
module ref_loss_monitor #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             fb_tick,
    input  logic [THR_W-1:0] thresh,
    input  logic             rail_lo,
    input  logic             rail_hi,
    output logic             lor
);
    localparam int CNT_W = THR_W + 1;

    logic             win_present;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    lor_window_fsm u_window (
        .clk         (clk),
        .rst         (rst),
        .ref_pulse   (ref_pulse),
        .fb_tick     (fb_tick),
        .win_present (win_present)
    );

    lor_miss_counter #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .fb_tick     (fb_tick),
        .win_present (win_present),
        .cnt_q       (cnt_q),
        .cnt_d       (cnt_d)
    );

    lor_flag_fsm #(.THR_W(THR_W), .CNT_W(CNT_W)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .cnt_d   (cnt_d),
        .thresh  (thresh),
        .rail_lo (rail_lo),
        .rail_hi (rail_hi),
        .lor     (lor)
    );

    AST_LOR_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (fb_tick && ref_pulse && !rail_lo && !rail_hi) |=> !lor);   // R7
    AST_LOR_TRIP: assert property (@(posedge clk) disable iff (rst)
        (fb_tick && !win_present && cnt_q >= CNT_W'(thresh)) |=> lor); // R4
endmodule

// File: tb/ref_loss_monitor_test.sv
module ref_loss_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int SAT_MAX    = 31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0;
    logic       fb_tick = 1'b0;
    logic [3:0] thresh = 4'd0;
    logic       rail_lo = 1'b0;
    logic       rail_hi = 1'b0;
    logic       lor;

    int n_vec = 0;
    int n_bad = 0;
    int m_cnt = 0;
    bit m_seen = 1'b0;
    bit m_lor = 1'b0;

    ref_loss_monitor #(.THR_W(4)) uut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_tick(fb_tick),
        .thresh(thresh), .rail_lo(rail_lo), .rail_hi(rail_hi), .lor(lor)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input bit exp);
        n_vec++;
        if (lor !== exp) begin
            n_bad++;
            $display("FAIL %s: lor=%0b expected %0b (thresh=%0d)", tag, lor, exp, thresh);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_pulse = 1'b0; fb_tick = 1'b0; rail_lo = 1'b0; rail_hi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_seen = 1'b0; m_lor = 1'b0;
        check("R1", 1'b0);
    endtask

    // one clock: drive at negedge, update the model at posedge, sample just after
    task automatic step(input bit r, input bit f, input bit lo, input bit hi, input string tag);
        bit present;
        @(negedge clk);
        ref_pulse = r; fb_tick = f; rail_lo = lo; rail_hi = hi;
        @(posedge clk);
        present = m_seen || r;
        if (f) begin
            if (present) m_cnt = 0;
            else if (m_cnt < SAT_MAX) m_cnt = m_cnt + 1;
            m_seen = 1'b0;
        end else begin
            m_seen = present;
        end
        m_lor = lo || hi || (m_cnt > int'(thresh));
        #1;
        check(tag, m_lor);
    endtask

    // one window of len cycles; pos < 0 means no reference pulse
    task automatic window(input int len, input int pos, input string tag);
        for (int i = 0; i < len; i++)
            step(i == pos, i == len - 1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < 16; t++) begin
            for (int len = 1; len <= 3; len++) begin
                thresh = 4'(t);
                do_reset();
                // R3 / R4: miss streak running just past the threshold
                for (int k = 0; k < t + 2; k++)
                    window(len, -1, (k + 1 > t) ? "R4" : "R3");
                // R7: present window with the pulse at every position
                for (int p = 0; p < len; p++) begin
                    window(len, p, "R7");
                    window(len, -1, "R3");
                end
                // R2: pulse on the closing cycle after a tripped streak
                for (int k = 0; k <= t; k++) window(len, -1, "R4");
                window(len, len - 1, "R2");
                // R8: pulse in one window, none in the next
                window(len, 0, "R8");
                window(len, -1, "R8");
                window(len, 0, "R8");
                // R6: each rail flag alone, then both together
                step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
                step(1'b0, 1'b0, 1'b0, 1'b1, "R6");
                step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
                window(len, 0, "R7");
                // R6: rail flag on the closing cycle of a present window keeps lor high
                step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
                window(len, 0, "R7");
            end
            // R5: long outage must not wrap the counter
            for (int k = 0; k < 40; k++) window(1, -1, "R5");
            window(1, 0, "R7");
        end
        // R1: a full counter is cleared by reset
        thresh = 4'd1;
        for (int k = 0; k < 35; k++) window(1, -1, "R5");
        do_reset();
        window(2, -1, "R1");
        window(2, -1, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule